// File: doc/BRIEF.md
# Storage Controller Host Register Block

This block is the memory-mapped control register set of a queue-based storage controller. A host reaches it over a simple 32-bit read/write port. It holds a fixed capability word, a fixed version word, an interrupt mask, the controller configuration word, a status word, the admin queue size word and the two 64-bit admin queue base addresses. It also holds the enable handshake that brings the admin queues up.

When the host turns the enable bit on, the block checks the configuration against its limits in the same write. The checks cover the page size, both entry sizes, both admin base addresses and both admin queue sizes. The status then shows either ready or fatal. A successful enable gives a one-cycle admin start pulse. The queue logic then takes the admin bases and sizes from dedicated outputs. Turning enable off, or starting a shutdown, gives a one-cycle teardown pulse to the queue logic. The interrupt mask is changed through a set location and a clear location.

Top module: `hcr_block`

## Requirements
- R1: After reset the mask, configuration, status, queue size word and both bases read 0. The mask output is 0, and the teardown and admin start outputs are low.
- R2: Offset 0x00 reads 0x0F0307FF: max entries 0x7FF in bits 15:0, contiguous-queue bit 16, arbitration field 1 in bits 18:17, timeout 0xF in bits 31:24. Offset 0x04 reads the command set field 1 at bit 5, the minimum page field at bits 19:16 and the maximum page field at bits 23:20. Offset 0x08 reads 0x00010001. Writes to these three offsets change nothing.
- R3: A write to 0x0C ORs the data into the mask, and a write to 0x10 clears the bits that are set in the data. Both offsets read the mask, and the mask output carries it. The mask changes only on such writes.
- R4: 0x24 is the queue size word: submission entries minus one in bits 11:0, completion entries minus one in bits 27:16. 0x28/0x2C are the low and high halves of the submission base, and 0x30/0x34 are those of the completion base. Each half can be written alone, reads back, and drives the matching output.
- R5: The configuration word at 0x14 has enable at bit 0, page field at 10:7 (page = 4096 << field), shutdown field at 15:14, submission entry size at 19:16 and completion entry size at 23:20. A write that raises enable stores the data. If the check passes, the status becomes exactly 0x1 (ready, bit 0), and admin start pulses for one cycle.
- R6: The enable check fails if either base is zero or has a bit set below the page size, or if the page field is outside [minimum, maximum]. It also fails if the submission size is not 6 or the completion size is not 4, or if either queue size field is 0. On failure the data is stored, the status becomes exactly 0x2 (fatal, bit 1), and no start pulse appears.
- R7: A write to 0x14 that neither changes the enable bit nor moves the shutdown field between zero and nonzero leaves the configuration and the status unchanged.
- R8: A write that lowers enable pulses teardown for one cycle, sets the configuration to 0 and clears ready. The fatal bit is kept.
- R9: A write that moves the stored shutdown field from zero to nonzero pulses teardown, stores the data and sets status bits 3:2 to 2'b10. A write that returns a nonzero stored field to zero stores the data and clears bits 3:2. A write that lowers enable first zeroes the stored field, so in that same write bits 3:2 stay as they were.
- R10: Reads of unaligned addresses, reserved offsets (0x18, 0x1C..0x20 apart from status, 0x38 and above) return 0. Writes there change nothing.
- R11: Read data is registered: it is valid in the cycle after the read strobe, and it is 0 after any cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| intr_mask | output | 32 | Current interrupt mask |
| teardown_req | output | 1 | One-cycle queue teardown request |
| admin_start | output | 1 | One-cycle pulse after a successful enable |
| adm_sq_base | output | 64 | Admin submission base address |
| adm_cq_base | output | 64 | Admin completion base address |
| adm_sq_last | output | 12 | Admin submission entries minus one |
| adm_cq_last | output | 12 | Admin completion entries minus one |

## Verification
Every result is due one clock edge after its strobe. Read data, the teardown pulse and the admin start pulse show up in the cycle after the strobe edge. Register state shows up in any read issued after a write. The bench drives each strobe for one cycle from a falling edge. It samples the pulses and the read data at the next falling edge, which is the single cycle in which they are valid. State is checked with a separate read afterwards. The enable check is swept over all page, submission and completion size values and over base and size corner cases. The bench derives the expected pass or fail from the field values.

// File: rtl/hcr_pkg.sv
package hcr_pkg;

    // Byte offsets within the block (decoded by host software).
    localparam logic [31:0] OFS_CAP_LO = 32'h00;
    localparam logic [31:0] OFS_CAP_HI = 32'h04;
    localparam logic [31:0] OFS_VER    = 32'h08;
    localparam logic [31:0] OFS_MSET   = 32'h0C;
    localparam logic [31:0] OFS_MCLR   = 32'h10;
    localparam logic [31:0] OFS_CFG    = 32'h14;
    localparam logic [31:0] OFS_STS    = 32'h1C;
    localparam logic [31:0] OFS_QSZ    = 32'h24;
    localparam logic [31:0] OFS_SQB_LO = 32'h28;
    localparam logic [31:0] OFS_SQB_HI = 32'h2C;
    localparam logic [31:0] OFS_CQB_LO = 32'h30;
    localparam logic [31:0] OFS_CQB_HI = 32'h34;

    // Configuration word fields.
    localparam int CFG_EN      = 0;
    localparam int CFG_PAGE_LO = 7;
    localparam int CFG_SHN_LO  = 14;
    localparam int CFG_SQE_LO  = 16;
    localparam int CFG_CQE_LO  = 20;

    // Status word fields.
    localparam int STS_RDY     = 0;
    localparam int STS_FATAL   = 1;
    localparam int STS_SHS_LO  = 2;
    localparam logic [1:0] SHS_DONE = 2'b10;

    // Queue size word fields.
    localparam int QSZ_SQ_LO = 0;
    localparam int QSZ_CQ_LO = 16;
    localparam int QSZ_W     = 12;

    // Fixed capability content.
    localparam int CAP_MAX_ENT  = 'h7FF;
    localparam int CAP_CONTIG   = 1;
    localparam int CAP_ARB      = 1;
    localparam int CAP_TMO      = 'hF;
    localparam int CAP_CMDSET   = 1;
    localparam logic [31:0] VER_WORD = 32'h0001_0001;

    // Smallest page is 2^PAGE_SHIFT0 bytes.
    localparam int PAGE_SHIFT0 = 12;

    typedef struct packed {
        logic [31:0] mask;
        logic [31:0] cfg;
        logic [31:0] sts;
        logic [31:0] qsz;
        logic [63:0] sqb;
        logic [63:0] cqb;
        logic        tdn;
        logic        go;
        logic [31:0] rdata;
    } hcr_state_t;

endpackage

// File: rtl/hcr_cap_const.sv
module hcr_cap_const
    import hcr_pkg::*;
#(
    parameter int PAGE_MIN = 0,
    parameter int PAGE_MAX = 0
) (
    output logic [63:0] cap,
    output logic [31:0] ver
);
    logic [31:0] lo_w;
    logic [31:0] hi_w;

    always_comb begin
        lo_w = {8'(CAP_TMO), 5'b0, 2'(CAP_ARB), 1'(CAP_CONTIG), 16'(CAP_MAX_ENT)};
        hi_w = {8'b0, 4'(PAGE_MAX), 4'(PAGE_MIN), 3'b0, 8'(CAP_CMDSET), 5'b0};
    end

    assign cap = {hi_w, lo_w};
    assign ver = VER_WORD;
endmodule

// File: rtl/hcr_cfg_check.sv
module hcr_cfg_check
    import hcr_pkg::*;
#(
    parameter int PAGE_MIN = 0,
    parameter int PAGE_MAX = 0,
    parameter int SQE_MIN  = 6,
    parameter int SQE_MAX  = 6,
    parameter int CQE_MIN  = 4,
    parameter int CQE_MAX  = 4
) (
    input  logic [3:0]        page_fld,
    input  logic [3:0]        sqe_fld,
    input  logic [3:0]        cqe_fld,
    input  logic [QSZ_W-1:0]  sq_last,
    input  logic [QSZ_W-1:0]  cq_last,
    input  logic [63:0]       sq_base,
    input  logic [63:0]       cq_base,
    output logic              cfg_ok
);
    logic [63:0] low_bits;
    logic        bases_ok, page_ok, ent_ok, size_ok;

    always_comb begin
        low_bits = (64'd1 << (PAGE_SHIFT0 + int'(page_fld))) - 64'd1;
        bases_ok = (sq_base != 64'd0) && (cq_base != 64'd0) &&
                   ((sq_base & low_bits) == 64'd0) &&
                   ((cq_base & low_bits) == 64'd0);
        page_ok  = (int'(page_fld) >= PAGE_MIN) && (int'(page_fld) <= PAGE_MAX);
        ent_ok   = (int'(sqe_fld) >= SQE_MIN) && (int'(sqe_fld) <= SQE_MAX) &&
                   (int'(cqe_fld) >= CQE_MIN) && (int'(cqe_fld) <= CQE_MAX);
        // A field of QSZ_W bits cannot pass the 4095 ceiling; only zero is out.
        size_ok  = (sq_last != '0) && (cq_last != '0);
        cfg_ok   = bases_ok && page_ok && ent_ok && size_ok;
    end
endmodule

// File: rtl/hcr_read_mux.sv
module hcr_read_mux
    import hcr_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [63:0]       cap,
    input  logic [31:0]       ver,
    input  logic [31:0]       mask,
    input  logic [31:0]       cfg,
    input  logic [31:0]       sts,
    input  logic [31:0]       qsz,
    input  logic [63:0]       sqb,
    input  logic [63:0]       cqb,
    output logic [31:0]       word
);
    always_comb begin
        word = '0;
        case (32'(addr))
            OFS_CAP_LO: word = cap[31:0];
            OFS_CAP_HI: word = cap[63:32];
            OFS_VER:    word = ver;
            OFS_MSET:   word = mask;
            OFS_MCLR:   word = mask;
            OFS_CFG:    word = cfg;
            OFS_STS:    word = sts;
            OFS_QSZ:    word = qsz;
            OFS_SQB_LO: word = sqb[31:0];
            OFS_SQB_HI: word = sqb[63:32];
            OFS_CQB_LO: word = cqb[31:0];
            OFS_CQB_HI: word = cqb[63:32];
            default:    word = '0;
        endcase
    end
endmodule

// File: rtl/hcr_block.sv
module hcr_block
    import hcr_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int PAGE_MIN = 0,
    parameter int PAGE_MAX = 0,
    parameter int SQE_MIN  = 6,
    parameter int SQE_MAX  = 6,
    parameter int CQE_MIN  = 4,
    parameter int CQE_MAX  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [31:0]       intr_mask,
    output logic              teardown_req,
    output logic              admin_start,
    output logic [63:0]       adm_sq_base,
    output logic [63:0]       adm_cq_base,
    output logic [11:0]       adm_sq_last,
    output logic [11:0]       adm_cq_last
);
    hcr_state_t st_q, st_d;

    logic [63:0] cap_w;
    logic [31:0] ver_w;
    logic [31:0] rd_word;
    logic        cand_ok;

    hcr_cap_const #(
        .PAGE_MIN(PAGE_MIN),
        .PAGE_MAX(PAGE_MAX)
    ) u_cap (
        .cap(cap_w),
        .ver(ver_w)
    );

    // Check the incoming configuration word against the stored admin setup.
    hcr_cfg_check #(
        .PAGE_MIN(PAGE_MIN), .PAGE_MAX(PAGE_MAX),
        .SQE_MIN(SQE_MIN),   .SQE_MAX(SQE_MAX),
        .CQE_MIN(CQE_MIN),   .CQE_MAX(CQE_MAX)
    ) u_chk_cfg (
        .page_fld(bus_wdata[CFG_PAGE_LO +: 4]),
        .sqe_fld (bus_wdata[CFG_SQE_LO +: 4]),
        .cqe_fld (bus_wdata[CFG_CQE_LO +: 4]),
        .sq_last (st_q.qsz[QSZ_SQ_LO +: QSZ_W]),
        .cq_last (st_q.qsz[QSZ_CQ_LO +: QSZ_W]),
        .sq_base (st_q.sqb),
        .cq_base (st_q.cqb),
        .cfg_ok  (cand_ok)
    );

    hcr_read_mux #(
        .ADDR_W(ADDR_W)
    ) u_rmux (
        .addr(bus_addr),
        .cap (cap_w),
        .ver (ver_w),
        .mask(st_q.mask),
        .cfg (st_q.cfg),
        .sts (st_q.sts),
        .qsz (st_q.qsz),
        .sqb (st_q.sqb),
        .cqb (st_q.cqb),
        .word(rd_word)
    );

    always_comb begin
        st_d       = st_q;
        st_d.tdn   = 1'b0;
        st_d.go    = 1'b0;
        st_d.rdata = '0;

        if (bus_rd) begin
            st_d.rdata = rd_word;
        end

        if (bus_wr) begin
            case (32'(bus_addr))
                OFS_MSET:   st_d.mask = st_q.mask | bus_wdata;
                OFS_MCLR:   st_d.mask = st_q.mask & ~bus_wdata;
                OFS_QSZ:    st_d.qsz  = bus_wdata;
                OFS_SQB_LO: st_d.sqb[31:0]  = bus_wdata;
                OFS_SQB_HI: st_d.sqb[63:32] = bus_wdata;
                OFS_CQB_LO: st_d.cqb[31:0]  = bus_wdata;
                OFS_CQB_HI: st_d.cqb[63:32] = bus_wdata;
                OFS_CFG: begin
                    // Enable transitions first.
                    if (bus_wdata[CFG_EN] && !st_q.cfg[CFG_EN]) begin
                        st_d.cfg = bus_wdata;
                        st_d.sts = '0;
                        if (cand_ok) begin
                            st_d.sts[STS_RDY] = 1'b1;
                            st_d.go           = 1'b1;
                        end else begin
                            st_d.sts[STS_FATAL] = 1'b1;
                        end
                    end else if (!bus_wdata[CFG_EN] && st_q.cfg[CFG_EN]) begin
                        st_d.cfg          = '0;
                        st_d.sts[STS_RDY] = 1'b0;
                        st_d.tdn          = 1'b1;
                    end
                    // Shutdown transitions, seen against the word left above.
                    if ((bus_wdata[CFG_SHN_LO +: 2] != 2'b00) &&
                        (st_d.cfg[CFG_SHN_LO +: 2] == 2'b00)) begin
                        st_d.cfg                   = bus_wdata;
                        st_d.sts[STS_SHS_LO +: 2]  = SHS_DONE;
                        st_d.tdn                   = 1'b1;
                    end else if ((bus_wdata[CFG_SHN_LO +: 2] == 2'b00) &&
                                 (st_d.cfg[CFG_SHN_LO +: 2] != 2'b00)) begin
                        st_d.cfg                   = bus_wdata;
                        st_d.sts[STS_SHS_LO +: 2]  = 2'b00;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata    = st_q.rdata;
    assign intr_mask    = st_q.mask;
    assign teardown_req = st_q.tdn;
    assign admin_start  = st_q.go;
    assign adm_sq_base  = st_q.sqb;
    assign adm_cq_base  = st_q.cqb;
    assign adm_sq_last  = st_q.qsz[QSZ_SQ_LO +: QSZ_W];
    assign adm_cq_last  = st_q.qsz[QSZ_CQ_LO +: QSZ_W];
endmodule

// File: rtl/hcr_block_chk.sv
module hcr_block_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [31:0] bus_rdata,
    input logic [31:0] intr_mask,
    input logic        teardown_req,
    input logic        admin_start,
    input logic        cfg_en,
    input logic [1:0]  cfg_shn,
    input logic        sts_ready,
    input logic        sts_fatal
);
    // R5
    ready_fatal_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sts_ready && sts_fatal));

    // R5
    start_means_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        admin_start |-> (sts_ready && cfg_en));

    // R3
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(intr_mask));

    // R8
    teardown_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        teardown_req |-> $past(bus_wr));

    // R9
    teardown_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        teardown_req |-> (!cfg_en || (cfg_shn != 2'b00)));

    // R11
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == 32'd0));
endmodule

bind hcr_block hcr_block_chk u_hcr_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_rdata   (bus_rdata),
    .intr_mask   (intr_mask),
    .teardown_req(teardown_req),
    .admin_start (admin_start),
    .cfg_en      (st_q.cfg[0]),
    .cfg_shn     (st_q.cfg[15:14]),
    .sts_ready   (st_q.sts[0]),
    .sts_fatal   (st_q.sts[1])
);

// File: tb/sim_hcr_block.sv
`timescale 1ns/1ps
module sim_hcr_block;
    localparam int AW    = 12;
    localparam int PMIN  = 0;
    localparam int PMAX  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, intr_mask;
    logic        teardown_req, admin_start;
    logic [63:0] adm_sq_base, adm_cq_base;
    logic [11:0] adm_sq_last, adm_cq_last;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic seen_td, seen_go;

    always #5 clk = ~clk;

    hcr_block #(.ADDR_W(AW), .PAGE_MIN(PMIN), .PAGE_MAX(PMAX)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .intr_mask(intr_mask), .teardown_req(teardown_req),
        .admin_start(admin_start), .adm_sq_base(adm_sq_base),
        .adm_cq_base(adm_cq_base), .adm_sq_last(adm_sq_last),
        .adm_cq_last(adm_cq_last)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        seen_td = teardown_req;
        seen_go = admin_start;
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = AW'(a);
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rd_chk(input logic [31:0] a, input logic [31:0] exp, input string req);
        logic [31:0] v;
        rd(a, v);
        chk(v == exp, req, v, exp);
    endtask

    function automatic logic [31:0] mkcfg(input bit en, input int pg, input int shn,
                                          input int sqe, input int cqe);
        return 32'(en) | (32'(pg) << 7) | (32'(shn) << 14) | (32'(sqe) << 16) | (32'(cqe) << 20);
    endfunction

    logic [63:0] m_sqb, m_cqb;
    logic [31:0] m_qsz;

    function automatic bit expect_ok(input logic [31:0] c);
        int pg; logic [63:0] lm;
        pg = int'(c[10:7]);
        lm = (64'd1 << (12 + pg)) - 64'd1;
        return (m_sqb != 0) && (m_cqb != 0) && ((m_sqb & lm) == 0) && ((m_cqb & lm) == 0) &&
               (pg >= PMIN) && (pg <= PMAX) && (c[19:16] == 4'd6) && (c[23:20] == 4'd4) &&
               (m_qsz[11:0] != 0) && (m_qsz[27:16] != 0);
    endfunction

    task automatic set_admin(input logic [63:0] sb, input logic [63:0] cb, input logic [31:0] q);
        m_sqb = sb; m_cqb = cb; m_qsz = q;
        wr(32'h28, sb[31:0]); wr(32'h2C, sb[63:32]);
        wr(32'h30, cb[31:0]); wr(32'h34, cb[63:32]);
        wr(32'h24, q);
    endtask

    // Enable with word c, check outcome, then disable and check teardown.
    task automatic try_enable(input logic [31:0] c, input string req);
        bit ok;
        ok = expect_ok(c);
        wr(32'h14, c);
        chk(seen_go == ok, req, 64'(seen_go), 64'(ok));
        chk(seen_td == 1'b0, req, 64'(seen_td), 0);
        rd_chk(32'h1C, ok ? 32'h1 : 32'h2, req);
        rd_chk(32'h14, c, req);
        wr(32'h14, 32'h0);
        chk(seen_td == 1'b1, "R8 teardown", 64'(seen_td), 1);
        rd_chk(32'h14, 32'h0, "R8 cfg");
        rd_chk(32'h1C, ok ? 32'h0 : 32'h2, "R8 sts");
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=running exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, mm;
        logic [31:0] valid_c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk(intr_mask == 0 && teardown_req == 0 && admin_start == 0, "R1 outputs",
            {intr_mask, 30'b0, teardown_req, admin_start}, 0);
        for (int a = 'h0C; a <= 'h34; a += 4) rd_chk(32'(a), 32'h0, "R1 regs");

        // R2 fixed words, and writes to them ignored
        rd_chk(32'h00, 32'h0F0307FF, "R2 cap lo");
        rd_chk(32'h04, (32'(PMAX) << 20) | (32'(PMIN) << 16) | 32'h20, "R2 cap hi");
        rd_chk(32'h08, 32'h00010001, "R2 ver");
        wr(32'h00, 32'hFFFF_FFFF); wr(32'h04, 32'hFFFF_FFFF); wr(32'h08, 32'h0);
        rd_chk(32'h00, 32'h0F0307FF, "R2 cap lo ro");
        rd_chk(32'h04, (32'(PMAX) << 20) | (32'(PMIN) << 16) | 32'h20, "R2 cap hi ro");
        rd_chk(32'h08, 32'h00010001, "R2 ver ro");

        // R3 mask set / clear sweep
        mm = 0;
        for (int i = 0; i < 16; i++) begin
            logic [31:0] s, c;
            s = 32'h1 << (2 * i) | 32'(i * 32'h0101_0000);
            c = 32'hF << i;
            wr(32'h0C, s); mm |= s;
            rd_chk(32'h0C, mm, "R3 set");
            wr(32'h10, c); mm &= ~c;
            rd_chk(32'h10, mm, "R3 clr");
            chk(intr_mask == mm, "R3 out", intr_mask, mm);
        end
        wr(32'h10, 32'hFFFF_FFFF);
        rd_chk(32'h0C, 32'h0, "R3 clear all");

        // R4 halves independent
        wr(32'h28, 32'hDEAD_0000); wr(32'h2C, 32'h0000_0012);
        wr(32'h30, 32'h0000_3000); wr(32'h34, 32'hABCD_0001);
        wr(32'h28, 32'h1234_5000);
        rd_chk(32'h28, 32'h1234_5000, "R4 sq lo");
        rd_chk(32'h2C, 32'h0000_0012, "R4 sq hi");
        rd_chk(32'h34, 32'hABCD_0001, "R4 cq hi");
        wr(32'h24, 32'h0ABC_0123);
        chk(adm_sq_base == 64'h12_1234_5000 && adm_cq_base == 64'hABCD_0001_0000_3000,
            "R4 base out", adm_sq_base, 64'h12_1234_5000);
        chk(adm_sq_last == 12'h123 && adm_cq_last == 12'hABC, "R4 size out",
            {adm_sq_last, adm_cq_last}, 24'h123ABC);

        // R5 / R6 page field sweep
        set_admin(64'h1_0000_0000, 64'h10_0000, 32'h001F_003F);
        for (int p = 0; p < 16; p++) try_enable(mkcfg(1, p, 0, 6, 4), "R5 R6 page");
        // R6 entry size sweep
        for (int s = 0; s < 16; s++)
            for (int c = 0; c < 16; c++) try_enable(mkcfg(1, 0, 0, s, c), "R6 entry");
        // R6 base corners
        set_admin(64'h0, 64'h10_0000, 32'h001F_003F); try_enable(mkcfg(1, 0, 0, 6, 4), "R6 sq zero");
        set_admin(64'h1000, 64'h0, 32'h001F_003F);    try_enable(mkcfg(1, 0, 0, 6, 4), "R6 cq zero");
        set_admin(64'h2000, 64'h8000, 32'h001F_003F);
        for (int p = 0; p < 3; p++) try_enable(mkcfg(1, p, 0, 6, 4), "R6 align");
        set_admin(64'h1000, 64'h1001, 32'h001F_003F); try_enable(mkcfg(1, 0, 0, 6, 4), "R6 cq unal");
        // R6 queue size corners
        set_admin(64'h4000, 64'h8000, 32'h001F_0000); try_enable(mkcfg(1, 0, 0, 6, 4), "R6 sq size");
        set_admin(64'h4000, 64'h8000, 32'h0000_003F); try_enable(mkcfg(1, 0, 0, 6, 4), "R6 cq size");
        set_admin(64'h4000, 64'h8000, 32'h0FFF_0FFF); try_enable(mkcfg(1, 0, 0, 6, 4), "R5 max size");
        set_admin(64'h4000, 64'h8000, 32'h0001_0001); try_enable(mkcfg(1, 0, 0, 6, 4), "R5 min size");

        // R7 re-enable ignored while enabled
        valid_c = mkcfg(1, 1, 0, 6, 4);
        wr(32'h14, valid_c);
        chk(seen_go == 1, "R5 go", 64'(seen_go), 1);
        wr(32'h14, mkcfg(1, 2, 0, 6, 4));
        chk(seen_go == 0 && seen_td == 0, "R7 no pulse", {seen_go, seen_td}, 0);
        rd_chk(32'h14, valid_c, "R7 cfg kept");
        rd_chk(32'h1C, 32'h1, "R7 sts kept");

        // R9 shutdown while enabled
        wr(32'h14, valid_c | (32'h1 << 14));
        chk(seen_td == 1, "R9 shn td", 64'(seen_td), 1);
        rd_chk(32'h1C, 32'h9, "R9 shn sts");
        rd_chk(32'h14, valid_c | (32'h1 << 14), "R9 shn cfg");
        wr(32'h14, valid_c);
        chk(seen_td == 0, "R9 clr td", 64'(seen_td), 0);
        rd_chk(32'h1C, 32'h1, "R9 clr sts");
        // R9 disable in same write as clearing field: shutdown status kept
        wr(32'h14, valid_c | (32'h2 << 14));
        wr(32'h14, 32'h0);
        chk(seen_td == 1, "R8 R9 td", 64'(seen_td), 1);
        rd_chk(32'h1C, 32'h8, "R9 kept sts");
        rd_chk(32'h14, 32'h0, "R9 kept cfg");
        // R9 shutdown from idle, then clear
        wr(32'h14, 32'h3 << 14);
        chk(seen_td == 1, "R9 idle td", 64'(seen_td), 1);
        rd_chk(32'h14, 32'h3 << 14, "R9 idle cfg");
        wr(32'h14, 32'h0);
        rd_chk(32'h1C, 32'h0, "R9 idle clr");

        // R10 reserved, out of block and unaligned
        wr(32'h18, 32'hFFFF_FFFF); wr(32'h0D, 32'hFFFF_FFFF); wr(32'h3C, 32'hFFFF_FFFF);
        rd_chk(32'h0C, 32'h0, "R10 mask untouched");
        rd_chk(32'h18, 32'h0, "R10 rsvd");
        rd_chk(32'h20, 32'h0, "R10 rsvd");
        rd_chk(32'h01, 32'h0, "R10 unaligned");
        rd_chk(32'h0A, 32'h0, "R10 unaligned");
        for (int a = 'h38; a < 'h1000; a += 'h1C4) rd_chk(32'(a), 32'h0, "R10 beyond");

        // R11 data valid only in the cycle after the strobe
        rd(32'h08, v);
        chk(v == 32'h00010001, "R11 due", v, 32'h00010001);
        @(negedge clk);
        chk(bus_rdata == 0, "R11 idle", bus_rdata, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule